// File: doc/BRIEF.md
# Infrared Wake Pattern Matcher

This block watches the demodulated output of an infrared receiver while the rest of the system sleeps. It cuts the receiver level into fixed-length cells. The cell length depends on the selected protocol family. It stores the cells of one frame and compares them, under a per-bit mask, with a pattern that software has loaded. The result goes into a small status register. Status bits that software has enabled drive a level wake output. The compare works on the raw cell pattern, not on decoded bits. So one matcher serves biphase codes, where each data bit is two cells (for example 1 → cells 1,0 and 0 → cells 0,1), and also pulse-distance codes.

Software reaches the block through a byte-wide register port with one address bus. A write strobe stores on the rising clock edge. Read data is combinational from the address. An index register chooses the array (compare or mask) and a starting byte, and each data write moves the byte pointer forward. A control register sets the protocol, the input polarity and the enable. A length register sets after how many cells the compare fires. A frame begins at the first mark cell after the line has been quiet. A run of quiet cells ends a frame. If that run comes before the length is reached, the frame is reported as short.

The frame controller has four states:
- IDLE: waits for a mark cell.
- COLLECT: stores cells.
- EVAL: one cycle of masked compare.
- WAIT_GAP: waits for the line to go quiet after a compared frame.

Its transitions are:
- start: IDLE→COLLECT on a mark cell, or IDLE→EVAL when the length is 1.
- reach: COLLECT→EVAL when the stored count equals the length, or 88 cells.
- gap: COLLECT→IDLE after 4 quiet cells (default), flagging a short frame.
- judge: EVAL→WAIT_GAP.
- rearm: WAIT_GAP→IDLE after the quiet run.
- disable: any state→IDLE while the enable bit is 0.

Top module: `ir_wake_matcher`

## Requirements
- R1: After reset every register reads 0 and `wake` is low.
- R2: Register addresses are 0 control, 1 status, 2 event enable, 3 index, 4 data and 5 length.
  - Index bits [5:4] select the array: 01 compare, 10 mask, anything else selects nothing. Index bits [3:0] hold the byte pointer.
  - A data write stores into the selected byte, but only if the pointer is below 11, and then increments the pointer modulo 16.
  - A data write with no array selected changes no array byte.
  - A data read returns the selected byte, or 0. An index read returns {00, select, pointer}.
- R3: Each cell value is the receiver level XOR control bit 3. It is sampled once per cell, half a cell after the last input edge and then every cell period.
- R4: With enable set and a nonzero length, a 1-cell seen in IDLE starts a frame and sets status bit 4. Cell k of the frame is stored at byte k/8, bit k%8.
- R5: When the cell count reaches the length (capped at 88), the masked compare runs in one cycle. If all masked bits are equal it sets status bit 0, otherwise status bit 1.
- R6: Cell bits whose mask bit is 0 do not affect the compare.
- R7: If 4 consecutive 0-cells arrive before the length is reached, the frame is abandoned and status bit 2 is set. The next 1-cell starts a new frame aligned at cell 0.
- R8: Writing 1 to status bits 0, 1, 2 or 4 clears them, and writing 0 leaves them. A set in the same cycle takes priority.
- R9: `wake` is the OR of (status bits [2:0] AND event enable bits [2:0]). It stays high until software clears the status or the enable.
- R10: With control bit 0 at 0, no frame starts and no status bit is set.
- R11: Control bits [5:4] select the cell period: 0 gives 8 clocks, 1 gives 12 clocks, 2 gives 6 clocks (defaults). Value 3 samples no cells, so no frames start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ir_rx | input | 1 | Demodulated receiver level (asynchronous) |
| wake | output | 1 | Wake request level |

## Verification
A wrong frame state or cell count shows up at the ports as a wrong status byte once the frame's quiet tail has passed. Examples are a match reported as short, a short frame reported as compared, or a miss. All of these can be read within about ten cell periods of the last cell. A wrong byte pointer or array select appears in the next data read-back. A status register that sets or clears wrongly shows on `wake` in the cycle after the write or the compare.

// File: rtl/ir_wake_pkg.sv
package ir_wake_pkg;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STS   = 3'd1;
    localparam logic [2:0] A_EVEN  = 3'd2;
    localparam logic [2:0] A_INDEX = 3'd3;
    localparam logic [2:0] A_DATA  = 3'd4;
    localparam logic [2:0] A_LEN   = 3'd5;

    localparam logic [1:0] SEL_CMP = 2'b01;
    localparam logic [1:0] SEL_MSK = 2'b10;

    localparam int STS_MATCH = 0;
    localparam int STS_MISS  = 1;
    localparam int STS_SHORT = 2;
    localparam int STS_START = 4;
    localparam logic [7:0] STS_W1C = 8'h17;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COLLECT  = 2'd1,
        ST_EVAL     = 2'd2,
        ST_WAIT_GAP = 2'd3
    } frame_state_t;

endpackage

// File: rtl/ir_wake_regs.sv
module ir_wake_regs
    import ir_wake_pkg::*;
#(
    parameter int N_BYTES = 11,
    parameter int LEN_W   = 8,
    parameter int AW      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             reg_addr,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [7:0]             set_bits,
    output logic                   ctl_en,
    output logic                   ctl_inv,
    output logic [1:0]             ctl_proto,
    output logic [LEN_W-1:0]       seq_len,
    output logic [N_BYTES*8-1:0]   cmp_flat,
    output logic [N_BYTES*8-1:0]   msk_flat,
    output logic [AW-1:0]          idx_addr,
    output logic                   wake
);

    logic [7:0]       sts_q;
    logic [2:0]       ev_q;
    logic [1:0]       sel_q;
    logic [AW-1:0]    ptr_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       cmp_m [N_BYTES];
    logic [7:0]       msk_m [N_BYTES];

    logic wr_ctrl, wr_sts, wr_even, wr_index, wr_data, wr_len;
    logic ptr_ok;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_sts   = reg_wr && (reg_addr == A_STS);
    assign wr_even  = reg_wr && (reg_addr == A_EVEN);
    assign wr_index = reg_wr && (reg_addr == A_INDEX);
    assign wr_data  = reg_wr && (reg_addr == A_DATA);
    assign wr_len   = reg_wr && (reg_addr == A_LEN);
    assign ptr_ok   = (int'(ptr_q) < N_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_proto <= 2'd0;
            ctl_inv   <= 1'b0;
            ctl_en    <= 1'b0;
            ev_q      <= 3'd0;
            len_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_proto <= reg_wdata[5:4];
                ctl_inv   <= reg_wdata[3];
                ctl_en    <= reg_wdata[0];
            end
            if (wr_even) ev_q  <= reg_wdata[2:0];
            if (wr_len)  len_q <= reg_wdata[LEN_W-1:0];
        end
    end

    // status: write-one-to-clear, a simultaneous set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 8'h00;
        end else begin
            sts_q <= (sts_q & ~(wr_sts ? (reg_wdata & STS_W1C) : 8'h00))
                   | (set_bits & STS_W1C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'd0;
            ptr_q <= '0;
        end else if (wr_index) begin
            sel_q <= reg_wdata[5:4];
            ptr_q <= reg_wdata[AW-1:0];
        end else if (wr_data) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) begin
                cmp_m[i] <= 8'h00;
                msk_m[i] <= 8'h00;
            end
        end else if (wr_data && ptr_ok) begin
            for (int i = 0; i < N_BYTES; i++) begin
                if (int'(ptr_q) == i) begin
                    if (sel_q == SEL_CMP) cmp_m[i] <= reg_wdata;
                    if (sel_q == SEL_MSK) msk_m[i] <= reg_wdata;
                end
            end
        end
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_flat
        assign cmp_flat[8*g +: 8] = cmp_m[g];
        assign msk_flat[8*g +: 8] = msk_m[g];
    end

    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            A_CTRL:  reg_rdata = {2'b00, ctl_proto, ctl_inv, 2'b00, ctl_en};
            A_STS:   reg_rdata = sts_q;
            A_EVEN:  reg_rdata = {5'd0, ev_q};
            A_INDEX: reg_rdata = {2'b00, sel_q, 4'(ptr_q)};
            A_DATA: begin
                if (ptr_ok && sel_q == SEL_CMP) reg_rdata = cmp_m[ptr_q];
                else if (ptr_ok && sel_q == SEL_MSK) reg_rdata = msk_m[ptr_q];
            end
            A_LEN:   reg_rdata = 8'(len_q);
            default: reg_rdata = 8'h00;
        endcase
    end

    assign seq_len  = len_q;
    assign idx_addr = ptr_q;
    assign wake     = |(sts_q[2:0] & ev_q);

endmodule

// File: rtl/ir_wake_sampler.sv
module ir_wake_sampler #(
    parameter int P_RC5 = 8,
    parameter int P_NEC = 12,
    parameter int P_RC6 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_rx,
    input  logic       en,
    input  logic       inv,
    input  logic [1:0] proto,
    output logic       cell_stb,
    output logic       cell_val
);

    localparam int PMAX = (P_RC5 > P_NEC) ? ((P_RC5 > P_RC6) ? P_RC5 : P_RC6)
                                          : ((P_NEC > P_RC6) ? P_NEC : P_RC6);
    localparam int CW = $clog2(PMAX + 1);

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic          active;
    logic          edge_seen;

    always_comb begin
        active = en;
        case (proto)
            2'd0:    period = CW'(P_RC5);
            2'd1:    period = CW'(P_NEC);
            2'd2:    period = CW'(P_RC6);
            default: begin
                period = CW'(P_RC6);
                active = 1'b0;
            end
        endcase
    end

    assign edge_seen = sync_q[1] ^ sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b000;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ir_rx};
            if (!active || edge_seen || (cnt_q >= period - 1'b1)) cnt_q <= '0;
            else cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cell_stb = active && !edge_seen && (cnt_q == (period >> 1));
    assign cell_val = sync_q[1] ^ inv;

endmodule

// File: rtl/ir_wake_frame.sv
module ir_wake_frame
    import ir_wake_pkg::*;
#(
    parameter int CELLS     = 88,
    parameter int LEN_W     = 8,
    parameter int GAP_CELLS = 4,
    parameter int CW        = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cell_stb,
    input  logic               cell_val,
    input  logic [LEN_W-1:0]   seq_len,
    input  logic [CELLS-1:0]   cmp_flat,
    input  logic [CELLS-1:0]   msk_flat,
    output logic [7:0]         set_bits,
    output frame_state_t       state,
    output logic [CW-1:0]      cell_cnt
);

    localparam int ZW = $clog2(GAP_CELLS + 1);

    frame_state_t     state_n;
    logic [CELLS-1:0] rx_q;
    logic [ZW-1:0]    zrun_q;
    logic             start, reach, gap_hit, equal;

    assign start   = cell_stb && cell_val && (seq_len != '0);
    assign reach   = ((int'(cell_cnt) + 1) == int'(seq_len)) || ((int'(cell_cnt) + 1) >= CELLS);
    assign gap_hit = !cell_val && ((int'(zrun_q) + 1) >= GAP_CELLS);
    assign equal   = (((rx_q ^ cmp_flat) & msk_flat) == '0);

    always_comb begin
        state_n = state;
        if (!en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     if (start) state_n = (seq_len == LEN_W'(1)) ? ST_EVAL : ST_COLLECT;
                ST_COLLECT: begin
                    if (cell_stb) begin
                        if (reach)        state_n = ST_EVAL;
                        else if (gap_hit) state_n = ST_IDLE;
                    end
                end
                ST_EVAL:     state_n = ST_WAIT_GAP;
                ST_WAIT_GAP: if (cell_stb && gap_hit) state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            cell_cnt <= '0;
            zrun_q   <= '0;
        end else if (!en) begin
            cell_cnt <= '0;
            zrun_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        rx_q     <= CELLS'(1);
                        cell_cnt <= CW'(1);
                        zrun_q   <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (cell_stb) begin
                        if (int'(cell_cnt) < CELLS) rx_q[cell_cnt] <= cell_val;
                        cell_cnt <= cell_cnt + 1'b1;
                        zrun_q   <= cell_val ? '0 : zrun_q + 1'b1;
                    end
                end
                ST_EVAL: zrun_q <= '0;
                ST_WAIT_GAP: begin
                    if (cell_stb) zrun_q <= cell_val ? '0 : zrun_q + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        set_bits = 8'h00;
        if (en) begin
            unique case (state)
                ST_IDLE:    if (start) set_bits[STS_START] = 1'b1;
                ST_COLLECT: if (cell_stb && !reach && gap_hit) set_bits[STS_SHORT] = 1'b1;
                ST_EVAL: begin
                    if (equal) set_bits[STS_MATCH] = 1'b1;
                    else       set_bits[STS_MISS]  = 1'b1;
                end
                ST_WAIT_GAP: set_bits = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/ir_wake_matcher.sv
module ir_wake_matcher
    import ir_wake_pkg::*;
#(
    parameter int N_BYTES   = 11,
    parameter int LEN_W     = 8,
    parameter int P_RC5     = 8,
    parameter int P_NEC     = 12,
    parameter int P_RC6     = 6,
    parameter int GAP_CELLS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ir_rx,
    output logic       wake
);

    localparam int CELLS = N_BYTES * 8;
    localparam int AW    = $clog2(N_BYTES);
    localparam int CW    = $clog2(CELLS + 1);

    logic               ctl_en, ctl_inv;
    logic [1:0]         ctl_proto;
    logic [LEN_W-1:0]   seq_len;
    logic [CELLS-1:0]   cmp_flat, msk_flat;
    logic [AW-1:0]      idx_addr;
    logic [7:0]         set_bits;
    logic               cell_stb, cell_val;
    frame_state_t       fsm_state;
    logic [CW-1:0]      cell_cnt;

    ir_wake_regs #(.N_BYTES(N_BYTES), .LEN_W(LEN_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_bits(set_bits),
        .ctl_en(ctl_en), .ctl_inv(ctl_inv), .ctl_proto(ctl_proto), .seq_len(seq_len),
        .cmp_flat(cmp_flat), .msk_flat(msk_flat), .idx_addr(idx_addr), .wake(wake)
    );

    ir_wake_sampler #(.P_RC5(P_RC5), .P_NEC(P_NEC), .P_RC6(P_RC6)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ir_rx(ir_rx),
        .en(ctl_en), .inv(ctl_inv), .proto(ctl_proto),
        .cell_stb(cell_stb), .cell_val(cell_val)
    );

    ir_wake_frame #(.CELLS(CELLS), .LEN_W(LEN_W), .GAP_CELLS(GAP_CELLS), .CW(CW)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(ctl_en),
        .cell_stb(cell_stb), .cell_val(cell_val), .seq_len(seq_len),
        .cmp_flat(cmp_flat), .msk_flat(msk_flat),
        .set_bits(set_bits), .state(fsm_state), .cell_cnt(cell_cnt)
    );

endmodule

// File: rtl/ir_wake_matcher_chk.sv
module ir_wake_matcher_chk
    import ir_wake_pkg::*;
#(
    parameter int CELLS = 88,
    parameter int AW    = 4,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic          wake,
    input logic          ctl_en,
    input frame_state_t  fsm_state,
    input logic [7:0]    set_bits,
    input logic [CW-1:0] cell_cnt,
    input logic [AW-1:0] idx_addr
);

    p_wake_low_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wake);

    p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DATA) |=> (idx_addr == $past(idx_addr) + 1'b1));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cell_cnt) <= CELLS);

    p_one_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_bits[2:0]));

    p_eval_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EVAL) |=> (fsm_state != ST_EVAL));

    p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !reg_wr) |=> wake);

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (fsm_state == ST_IDLE));

endmodule

bind ir_wake_matcher ir_wake_matcher_chk #(.CELLS(CELLS), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .wake(wake),
    .ctl_en(ctl_en), .fsm_state(fsm_state), .set_bits(set_bits),
    .cell_cnt(cell_cnt), .idx_addr(idx_addr)
);

// File: tb/ir_wake_matcher_bench.sv
module ir_wake_matcher_bench;

    localparam int P_RC5 = 8;
    localparam int P_NEC = 12;
    localparam int P_RC6 = 6;
    localparam int GAP   = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       ir_rx;
    logic       wake;

    always #5 clk = ~clk;

    ir_wake_matcher #(.P_RC5(P_RC5), .P_NEC(P_NEC), .P_RC6(P_RC6), .GAP_CELLS(GAP)) u_ir_wake_matcher (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ir_rx(ir_rx), .wake(wake)
    );

    int    total = 0;
    int    bad   = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    int    act_q[$];
    string tag_q[$];

    // driver side: push expected and observed into the scoreboard
    task automatic check(input string tag, input int exp, input int act);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    // monitor side: pop and compare
    initial begin
        forever begin
            @(posedge clk);
            while (act_q.size() > 0) begin
                int    e, a;
                string t;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (e != a) begin
                    bad++;
                    $display("FAIL %s actual=0x%0h expected=0x%0h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #1;
        d = int'(reg_rdata);
    endtask

    function automatic logic [87:0] mk_cells(input logic [15:0] w);
        logic [87:0] c;
        c = '0;
        for (int i = 0; i < 16; i++) begin
            c[2*i]   = w[15-i];
            c[2*i+1] = ~w[15-i];
        end
        return c;
    endfunction

    task automatic send(input logic [87:0] c, input int n, input int p, input bit inv);
        for (int k = 0; k < n; k++) begin
            ir_rx = c[k] ^ inv;
            repeat (p) @(negedge clk);
        end
        ir_rx = inv;
        repeat ((2 * GAP + 2) * p) @(negedge clk);
    endtask

    task automatic expect_sts(input string tag, input int exp);
        int v;
        rd(3'd1, v);
        check(tag, exp, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [87:0] cells, c2;
        int v;
        rst_n = 1'b0; reg_addr = 3'd0; reg_wr = 1'b0; reg_wdata = 8'h00; ir_rx = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 wake", 0, int'(wake));
        rd(3'd0, v); check("R1 ctrl", 0, v);
        expect_sts("R1 status", 0);
        rd(3'd5, v); check("R1 length", 0, v);

        // R2 index/data access
        wr(3'd3, 8'h10); wr(3'd4, 8'h5A); wr(3'd4, 8'hC3);
        rd(3'd3, v); check("R2 pointer advanced", 8'h12, v);
        wr(3'd3, 8'h11); rd(3'd4, v); check("R2 compare byte1", 8'hC3, v);
        wr(3'd3, 8'h00); wr(3'd4, 8'hEE);
        wr(3'd3, 8'h10); rd(3'd4, v); check("R2 no-select write ignored", 8'h5A, v);
        wr(3'd3, 8'h20); rd(3'd4, v); check("R2 mask byte0", 8'h00, v);

        // load pattern: 16 data bits -> 32 cells
        cells = mk_cells(16'hA5C3);
        wr(3'd3, 8'h10);
        for (int i = 0; i < 11; i++) wr(3'd4, (i < 4) ? cells[8*i +: 8] : 8'h00);
        wr(3'd3, 8'h20);
        for (int i = 0; i < 11; i++) wr(3'd4, (i < 4) ? 8'hFF : 8'h00);
        wr(3'd5, 8'd32);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h21);

        // R4 R5 match
        send(cells, 32, P_RC6, 1'b0);
        expect_sts("R5 R4 match status", 8'h11);
        check("R9 wake on match", 1, int'(wake));

        // R8 W1C
        wr(3'd1, 8'h01);
        expect_sts("R8 clear match only", 8'h10);
        check("R9 wake dropped", 0, int'(wake));
        wr(3'd1, 8'h10);
        expect_sts("R8 clear start", 0);

        // R5 mismatch, R9 gating
        c2 = cells; c2[1] = 1'b1;
        send(c2, 32, P_RC6, 1'b0);
        expect_sts("R5 mismatch status", 8'h12);
        check("R9 miss not enabled", 0, int'(wake));
        wr(3'd2, 8'h02);
        check("R9 miss enabled", 1, int'(wake));
        wr(3'd1, 8'h17);
        check("R8 R9 full clear", 0, int'(wake));
        wr(3'd2, 8'h01);

        // R6 masked-out difference
        wr(3'd3, 8'h21); wr(3'd4, 8'hF0);
        c2 = cells;
        if (c2[8] == 1'b0) c2[8] = 1'b1; else c2[9] = 1'b1;
        send(c2, 32, P_RC6, 1'b0);
        expect_sts("R6 ignored bit", 8'h11);
        wr(3'd3, 8'h21); wr(3'd4, 8'hFF);
        wr(3'd1, 8'h17);

        // R7 short frame then realigned frame
        send(cells, 20, P_RC6, 1'b0);
        expect_sts("R7 short frame", 8'h14);
        wr(3'd1, 8'h17);
        send(cells, 32, P_RC6, 1'b0);
        expect_sts("R7 realigned match", 8'h11);
        wr(3'd1, 8'h17);

        // R3 inverted input
        wr(3'd0, 8'h20);
        ir_rx = 1'b1;
        repeat (5) @(negedge clk);
        wr(3'd0, 8'h29);
        repeat (3 * P_RC6) @(negedge clk);
        send(cells, 32, P_RC6, 1'b1);
        expect_sts("R3 inverted match", 8'h11);
        wr(3'd0, 8'h20);
        ir_rx = 1'b0;
        repeat (5) @(negedge clk);
        wr(3'd1, 8'h17);

        // R11 protocol 1 period
        wr(3'd0, 8'h11);
        send(cells, 32, P_NEC, 1'b0);
        expect_sts("R11 proto1 period match", 8'h11);
        wr(3'd1, 8'h17);

        // R11 reserved protocol
        wr(3'd0, 8'h31);
        send(cells, 32, P_RC6, 1'b0);
        expect_sts("R11 reserved no event", 0);

        // R10 disabled
        wr(3'd0, 8'h20);
        send(cells, 32, P_RC6, 1'b0);
        expect_sts("R10 disabled no event", 0);
        check("R10 wake low", 0, int'(wake));

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule